// File: doc/BRIEF.md
# Pulse Sequence Instruction Controller

This block is a small special-purpose controller that steps through a stored list of timing instructions. Every output change lands on a cycle that is fixed by the program alone. It drives a bank of synchronous digital output words and issues addressed writes to remote synthesizer or DAC nodes on a peripheral bus. Execution can branch on a bitmask of eight trigger inputs. Finite loops and subroutines let a long pulse pattern be written compactly.

A run begins with a one-cycle start strobe. The controller fetches from an instruction memory through an address/data read port, with the data returned in the same cycle. Every instruction except a wait takes exactly one cycle. A wait lasts the number of cycles it carries. A halt instruction ends the run and raises done. A stack overflow or underflow ends it and raises a sticky error flag instead. In both cases the outputs keep their last values.

Top module: `pulse_seq_ctrl`

## Requirements
- R1: While reset is held and on the cycle after it is released, busy, done, errFlag and busValid are 0, ttlOut is all zeros and instrAddr is 0.
- R2: A start pulse seen while busy and errFlag are both low sets busy and clears done at the next edge, sets instrAddr to 0 and empties both stacks. A start seen while busy is high, or while errFlag is high, has no effect.
- R3: An instruction is 40 bits. Bits [39:36] hold the opcode: 0 halt, 1 wait, 2 jump, 3 conditional jump, 4 loop open, 5 loop close, 6 call, 7 return, 8 digital write, 9 bus write. The word at instrAddr is used in the same cycle, and every instruction other than a wait occupies exactly one cycle.
- R4: A wait with count N in bits [35:0] occupies N cycles before the next instruction issues. A count of 0 behaves as 1.
- R5: A digital write places bits [15:0] into output word S, which is ttlOut[S*16 +: 16], where S is bits [23:16]; the new value shows after the clock edge that ends the instruction. A value of S with no matching word changes nothing.
- R6: A bus write raises busValid for exactly one cycle after its edge, with busAddr set to bits [23:16] and busData set to bits [15:0]. busAddr and busData then hold until the next bus write.
- R7: A jump continues at the address in bits [15:0], truncated to the address width.
- R8: A conditional jump goes to the address in bits [15:0] when every trigger input selected by the mask in bits [23:16] is high in its execute cycle; otherwise the next instruction follows. A mask of 0 always branches.
- R9: A loop open with count C in bits [15:0] (0 behaves as 1) pushes C. A loop close branches to the address in bits [15:0] while the innermost count is above 1 and decrements it; otherwise it pops and falls through. The body therefore runs C times, and loops nest up to the stack depth (default 4).
- R10: A call pushes the address of the next instruction and jumps to bits [15:0]. A return continues at the most recently pushed address.
- R11: A call or loop open with its 4-entry stack full, or a return or loop close with its stack empty, sets errFlag and clears busy at the next edge, leaves done low and holds every output. errFlag stays set until reset.
- R12: A halt clears busy and sets done at the next edge. Done, ttlOut, busAddr and busData then hold until the next start, and busValid stays low.
- R13: Opcodes 10 to 15 are one-cycle no-ops that change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle run request |
| trig | input | 8 | Trigger inputs tested by conditional jumps |
| instrAddr | output | ADDR_W | Instruction memory read address |
| instrData | input | 40 | Instruction word at instrAddr, same cycle |
| ttlOut | output | 16*TTL_SLICES | Digital output words |
| busValid | output | 1 | One-cycle peripheral write strobe |
| busAddr | output | 8 | Peripheral node address |
| busData | output | 16 | Peripheral write value |
| busy | output | 1 | Program running |
| done | output | 1 | Program ended on a halt |
| errFlag | output | 1 | Sticky stack fault |

## Verification
The bench counts the exact number of busy cycles for each program and takes a snapshot of the outputs on every cycle. A wait that is off by one, or that treats a zero count as zero cycles, shifts the digital write that follows it and changes the run length. The loop tests cover a count of one and of zero, and a nested pair. A loop close that tests the count before or after the decrement on the wrong side produces one bus pulse too many or too few. The fault tests recurse past the stack depth, loop past it, and return with an empty stack. A design that wraps its stack pointer instead of faulting would keep running, so errFlag would stay low and the busy-cycle count would change. A start pulse in the middle of a run must not restart the program. If it did, the run would grow by several cycles.

// File: rtl/pseq_pkg.sv
`timescale 1ns/1ps
package pseq_pkg;
  localparam int INSTR_W = 40;
  localparam int OP_LSB  = 36;
  localparam int WAIT_W  = 36;
  localparam int SEL_W   = 8;
  localparam int VAL_W   = 16;
  localparam int TRIG_W  = 8;
  localparam int WORD_W  = 16;

  typedef enum logic [3:0] {
    OP_HALT    = 4'd0,
    OP_WAIT    = 4'd1,
    OP_JUMP    = 4'd2,
    OP_JUMPIF  = 4'd3,
    OP_LOOP    = 4'd4,
    OP_ENDLOOP = 4'd5,
    OP_CALL    = 4'd6,
    OP_RET     = 4'd7,
    OP_TTL     = 4'd8,
    OP_BUS     = 4'd9
  } op_e;

  // strobes and operands handed from the control to the datapath
  typedef struct packed {
    logic             ttlWr;
    logic             busWr;
    logic [SEL_W-1:0] sel;
    logic [VAL_W-1:0] val;
  } dp_ctrl_t;
endpackage

// File: rtl/pseq_stack.sv
`timescale 1ns/1ps
module pseq_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         push,
  input  logic         pop,
  input  logic         setTop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] topIdx;
  logic [IDX_W-1:0] wrIdx;

  assign topIdx = IDX_W'(cnt - 1'b1);
  assign wrIdx  = IDX_W'(cnt);
  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign top    = empty ? '0 : slots[topIdx];

  always_ff @(posedge clk) begin
    if (rst || clear)      cnt <= '0;
    else if (push && !full) cnt <= cnt + 1'b1;
    else if (pop && !empty) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!clear) begin
      if (push && !full)         slots[wrIdx]  <= din;
      else if (setTop && !empty) slots[topIdx] <= din;
    end
  end
endmodule

// File: rtl/pseq_control.sv
`timescale 1ns/1ps
module pseq_control
  import pseq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STACK_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [INSTR_W-1:0] instrData,
  input  logic               trigHit,
  output logic [ADDR_W-1:0]  instrAddr,
  output dp_ctrl_t           dpCtrl,
  output logic               busy,
  output logic               done,
  output logic               errFlag
);
  localparam int LOOP_W = VAL_W;

  logic [ADDR_W-1:0] pc, pcNext, pcInc, tgt;
  logic [WAIT_W-1:0] waitCnt, waitNext, waitArg;
  logic              runQ, doneQ, errQ;
  logic              launch, haltNow, faultNow;
  op_e               op;
  logic [VAL_W-1:0]  lo;
  logic [SEL_W-1:0]  mid;

  logic              retPush, retPop, retFull, retEmpty;
  logic [ADDR_W-1:0] retTop;
  logic              loopPush, loopPop, loopSet, loopFull, loopEmpty;
  logic [LOOP_W-1:0] loopTop, loopDin;

  assign op      = op_e'(instrData[INSTR_W-1:OP_LSB]);
  assign waitArg = instrData[WAIT_W-1:0];
  assign lo      = instrData[VAL_W-1:0];
  assign mid     = instrData[VAL_W+SEL_W-1:VAL_W];
  assign tgt     = lo[ADDR_W-1:0];
  assign pcInc   = pc + 1'b1;
  assign launch  = start && !runQ && !errQ;

  always_comb begin
    pcNext     = pcInc;
    waitNext   = waitCnt;
    retPush    = 1'b0;
    retPop     = 1'b0;
    loopPush   = 1'b0;
    loopPop    = 1'b0;
    loopSet    = 1'b0;
    haltNow    = 1'b0;
    faultNow   = 1'b0;
    loopDin    = (lo == '0) ? LOOP_W'(1) : lo;
    dpCtrl     = '0;
    dpCtrl.sel = mid;
    dpCtrl.val = lo;
    if (runQ) begin
      case (op)
        OP_HALT: begin
          haltNow = 1'b1;
          pcNext  = pc;
        end
        OP_WAIT: begin
          if (waitCnt == '0) begin
            if (waitArg > WAIT_W'(1)) begin
              waitNext = waitArg - 1'b1;
              pcNext   = pc;
            end
          end else begin
            waitNext = waitCnt - 1'b1;
            if (waitCnt != WAIT_W'(1)) pcNext = pc;
          end
        end
        OP_JUMP:   pcNext = tgt;
        OP_JUMPIF: if (trigHit) pcNext = tgt;
        OP_LOOP: begin
          if (loopFull) faultNow = 1'b1;
          else          loopPush = 1'b1;
        end
        OP_ENDLOOP: begin
          if (loopEmpty) faultNow = 1'b1;
          else if (loopTop > LOOP_W'(1)) begin
            loopSet = 1'b1;
            loopDin = loopTop - 1'b1;
            pcNext  = tgt;
          end else loopPop = 1'b1;
        end
        OP_CALL: begin
          if (retFull) faultNow = 1'b1;
          else begin
            retPush = 1'b1;
            pcNext  = tgt;
          end
        end
        OP_RET: begin
          if (retEmpty) faultNow = 1'b1;
          else begin
            retPop = 1'b1;
            pcNext = retTop;
          end
        end
        OP_TTL:  dpCtrl.ttlWr = 1'b1;
        OP_BUS:  dpCtrl.busWr = 1'b1;
        default: ;
      endcase
      if (faultNow) pcNext = pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ    <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
      pc      <= '0;
      waitCnt <= '0;
    end else if (launch) begin
      runQ    <= 1'b1;
      doneQ   <= 1'b0;
      pc      <= '0;
      waitCnt <= '0;
    end else if (runQ) begin
      pc      <= pcNext;
      waitCnt <= waitNext;
      if (haltNow) begin
        runQ  <= 1'b0;
        doneQ <= 1'b1;
      end
      if (faultNow) begin
        runQ <= 1'b0;
        errQ <= 1'b1;
      end
    end
  end

  pseq_stack #(.W(ADDR_W), .DEPTH(STACK_DEPTH)) u_retStack (
    .clk(clk), .rst(rst), .clear(launch),
    .push(retPush), .pop(retPop), .setTop(1'b0), .din(pcInc),
    .top(retTop), .full(retFull), .empty(retEmpty)
  );

  pseq_stack #(.W(LOOP_W), .DEPTH(STACK_DEPTH)) u_loopStack (
    .clk(clk), .rst(rst), .clear(launch),
    .push(loopPush), .pop(loopPop), .setTop(loopSet), .din(loopDin),
    .top(loopTop), .full(loopFull), .empty(loopEmpty)
  );

  assign instrAddr = pc;
  assign busy      = runQ;
  assign done      = doneQ;
  assign errFlag   = errQ;
endmodule

// File: rtl/pseq_datapath.sv
`timescale 1ns/1ps
module pseq_datapath
  import pseq_pkg::*;
#(
  parameter int TTL_SLICES = 2,
  localparam int OUT_W     = TTL_SLICES * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_ctrl_t          dpCtrl,
  input  logic [TRIG_W-1:0] trig,
  output logic              trigHit,
  output logic [OUT_W-1:0]  ttlOut,
  output logic              busValid,
  output logic [SEL_W-1:0]  busAddr,
  output logic [VAL_W-1:0]  busData
);
  assign trigHit = ((trig & dpCtrl.sel) == dpCtrl.sel);

  for (genvar s = 0; s < TTL_SLICES; s++) begin : g_word
    logic [WORD_W-1:0] word;
    always_ff @(posedge clk) begin
      if (rst) word <= '0;
      else if (dpCtrl.ttlWr && dpCtrl.sel == SEL_W'(s)) word <= dpCtrl.val;
    end
    assign ttlOut[s*WORD_W +: WORD_W] = word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busValid <= 1'b0;
      busAddr  <= '0;
      busData  <= '0;
    end else begin
      busValid <= dpCtrl.busWr;
      if (dpCtrl.busWr) begin
        busAddr <= dpCtrl.sel;
        busData <= dpCtrl.val;
      end
    end
  end
endmodule

// File: rtl/pulse_seq_ctrl.sv
`timescale 1ns/1ps
module pulse_seq_ctrl
  import pseq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TTL_SLICES  = 2,
  parameter int STACK_DEPTH = 4,
  localparam int OUT_W      = TTL_SLICES * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [TRIG_W-1:0]  trig,
  output logic [ADDR_W-1:0]  instrAddr,
  input  logic [INSTR_W-1:0] instrData,
  output logic [OUT_W-1:0]   ttlOut,
  output logic               busValid,
  output logic [SEL_W-1:0]   busAddr,
  output logic [VAL_W-1:0]   busData,
  output logic               busy,
  output logic               done,
  output logic               errFlag
);
  dp_ctrl_t dpCtrl;
  logic     trigHit;

  pseq_control #(.ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .instrData(instrData),
    .trigHit(trigHit), .instrAddr(instrAddr), .dpCtrl(dpCtrl),
    .busy(busy), .done(done), .errFlag(errFlag)
  );

  pseq_datapath #(.TTL_SLICES(TTL_SLICES)) u_dp (
    .clk(clk), .rst(rst), .dpCtrl(dpCtrl), .trig(trig), .trigHit(trigHit),
    .ttlOut(ttlOut), .busValid(busValid), .busAddr(busAddr), .busData(busData)
  );
endmodule

// File: rtl/pseq_checker.sv
`timescale 1ns/1ps
module pseq_checker #(
  parameter int ADDR_W = 8,
  parameter int OUT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] instrAddr,
  input logic [OUT_W-1:0]  ttlOut,
  input logic              busValid,
  input logic              busy,
  input logic              done,
  input logic              errFlag
);
  // R12: a finished run is never also running
  assert_busy_done_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R2: an accepted start launches from address zero
  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !errFlag) |=> (busy && !done && instrAddr == '0));

  // R6: a bus strobe only follows a running cycle
  assert_bus_from_run_R6: assert property (@(posedge clk) disable iff (rst)
    busValid |-> $past(busy));

  // R11: the fault flag never clears on its own
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  // R11: a fault stops the run without signalling completion
  assert_err_stops_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(errFlag) |-> (!busy && !done));

  // R12: after a halt the outputs hold until the next start
  assert_done_holds_R12: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(ttlOut) && !busValid));
endmodule

bind pulse_seq_ctrl pseq_checker #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .instrAddr(instrAddr), .ttlOut(ttlOut),
  .busValid(busValid), .busy(busy), .done(done), .errFlag(errFlag)
);

// File: tb/tb_pulse_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pulse_seq_ctrl;
  localparam int ADDR_W = 8;
  localparam int OUT_W  = 32;

  logic              clk = 1'b0;
  logic              rst, start;
  logic [7:0]        trig;
  logic [ADDR_W-1:0] instrAddr;
  logic [39:0]       instrData;
  logic [OUT_W-1:0]  ttlOut;
  logic              busValid, busy, done, errFlag;
  logic [7:0]        busAddr;
  logic [15:0]       busData;

  logic [39:0] mem [0:255];
  assign instrData = mem[instrAddr];

  always #2.5 clk = ~clk;

  pulse_seq_ctrl #(.ADDR_W(ADDR_W), .TTL_SLICES(2), .STACK_DEPTH(4)) dut (
    .clk(clk), .rst(rst), .start(start), .trig(trig), .instrAddr(instrAddr),
    .instrData(instrData), .ttlOut(ttlOut), .busValid(busValid),
    .busAddr(busAddr), .busData(busData), .busy(busy), .done(done),
    .errFlag(errFlag)
  );

  int total = 0;
  int bad   = 0;
  int nBusy, pulseCnt;
  logic [OUT_W-1:0] ttlLog [0:1023];
  logic [7:0]       pAddr [0:63];
  logic [15:0]      pData [0:63];

  localparam logic [3:0] HALT = 4'd0, JMP = 4'd2, JIF = 4'd3, LOOP = 4'd4,
                         ENDL = 4'd5, CALL = 4'd6, RET = 4'd7, TTL = 4'd8,
                         BUS = 4'd9;

  function automatic logic [39:0] ins(input logic [3:0] op, input logic [7:0] mid,
                                      input logic [15:0] lo);
    return {op, 12'h000, mid, lo};
  endfunction

  function automatic logic [39:0] insWait(input logic [35:0] n);
    return {4'd1, n};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic resetDut();
    rst = 1'b1; start = 1'b0; trig = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // launch a run and log outputs once per busy cycle
  task automatic runProg(input int restartAt);
    nBusy = 0; pulseCnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy && nBusy < 1000) begin
      nBusy++;
      ttlLog[nBusy] = ttlOut;
      if (busValid) begin
        if (pulseCnt < 64) begin
          pAddr[pulseCnt] = busAddr;
          pData[pulseCnt] = busData;
        end
        pulseCnt++;
      end
      start = (nBusy == restartAt);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; trig = '0;
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 errFlag", errFlag, 0);
    chk("R1 busValid", busValid, 0);
    chk("R1 ttlOut", ttlOut, 0);
    chk("R1 instrAddr", instrAddr, 0);
  endtask

  task automatic t_ttl_wait();
    clearMem();
    mem[0] = ins(TTL, 8'd0, 16'hA5A5);
    mem[1] = insWait(36'd5);
    mem[2] = ins(TTL, 8'd1, 16'h1234);
    mem[3] = ins(HALT, 0, 0);
    runProg(-1);
    chk("R4 wait5 run length", nBusy, 8);
    chk("R5 word0 after first edge", ttlLog[2][15:0], 16'hA5A5);
    chk("R3 word1 before its cycle", ttlLog[7][31:16], 16'h0000);
    chk("R5 word1 written", ttlLog[8][31:16], 16'h1234);
    chk("R12 done", done, 1);
    repeat (4) @(negedge clk);
    chk("R12 outputs hold", ttlOut, 32'h1234A5A5);
    chk("R12 done held", {busy, done}, 2'b01);
  endtask

  task automatic t_wait_short();
    clearMem();
    mem[0] = insWait(36'd0);
    mem[1] = insWait(36'd1);
    mem[2] = ins(HALT, 0, 0);
    runProg(-1);
    chk("R4 wait0 and wait1 one cycle each", nBusy, 3);
  endtask

  task automatic t_bus();
    clearMem();
    mem[0] = ins(BUS, 8'h3C, 16'hBEEF);
    mem[1] = ins(BUS, 8'h05, 16'h0001);
    mem[2] = ins(HALT, 0, 0);
    runProg(-1);
    chk("R6 pulse count", pulseCnt, 2);
    chk("R6 first write", {pAddr[0], pData[0]}, {8'h3C, 16'hBEEF});
    chk("R6 second write", {pAddr[1], pData[1]}, {8'h05, 16'h0001});
    chk("R6 strobe drops, fields hold", {busValid, busAddr, busData}, {1'b0, 8'h05, 16'h0001});
  endtask

  task automatic t_jump();
    clearMem();
    mem[0] = ins(JMP, 0, 16'd5);
    mem[1] = ins(TTL, 8'd0, 16'hDEAD);
    mem[5] = ins(TTL, 8'd0, 16'h0F0F);
    mem[6] = ins(HALT, 0, 0);
    runProg(-1);
    chk("R7 jump run length", nBusy, 3);
    chk("R7 jump target executed", ttlOut[15:0], 16'h0F0F);
  endtask

  task automatic t_cond();
    clearMem();
    mem[0] = ins(JIF, 8'h81, 16'd4);
    mem[1] = ins(TTL, 8'd0, 16'h1111);
    mem[2] = ins(HALT, 0, 0);
    mem[4] = ins(TTL, 8'd0, 16'h2222);
    mem[5] = ins(HALT, 0, 0);
    trig = 8'hFF;
    runProg(-1);
    chk("R8 all masked bits high taken", ttlOut[15:0], 16'h2222);
    trig = 8'h80;
    runProg(-1);
    chk("R8 partial match falls through", ttlOut[15:0], 16'h1111);
    mem[0] = ins(JIF, 8'h00, 16'd4);
    trig = 8'h00;
    runProg(-1);
    chk("R8 zero mask always taken", ttlOut[15:0], 16'h2222);
    trig = 8'h00;
  endtask

  task automatic t_loop();
    clearMem();
    mem[0] = ins(LOOP, 0, 16'd3);
    mem[1] = ins(BUS, 8'h01, 16'h0007);
    mem[2] = ins(ENDL, 0, 16'd1);
    mem[3] = ins(HALT, 0, 0);
    runProg(-1);
    chk("R9 loop of 3 pulses", pulseCnt, 3);
    chk("R9 loop of 3 run length", nBusy, 8);
    mem[0] = ins(LOOP, 0, 16'd0);
    runProg(-1);
    chk("R9 count zero runs once", pulseCnt, 1);
    clearMem();
    mem[0] = ins(LOOP, 0, 16'd2);
    mem[1] = ins(LOOP, 0, 16'd3);
    mem[2] = ins(BUS, 8'h02, 16'h0009);
    mem[3] = ins(ENDL, 0, 16'd2);
    mem[4] = ins(ENDL, 0, 16'd1);
    mem[5] = ins(HALT, 0, 0);
    runProg(-1);
    chk("R9 nested pulses", pulseCnt, 6);
    chk("R9 nested run length", nBusy, 18);
  endtask

  task automatic t_call();
    clearMem();
    mem[0]  = ins(CALL, 0, 16'd10);
    mem[1]  = ins(CALL, 0, 16'd10);
    mem[2]  = ins(HALT, 0, 0);
    mem[10] = ins(BUS, 8'h09, 16'h0055);
    mem[11] = ins(RET, 0, 0);
    runProg(-1);
    chk("R10 subroutine pulses", pulseCnt, 2);
    chk("R10 call run length", nBusy, 7);
    chk("R10 ends on halt", {done, errFlag}, 2'b10);
  endtask

  task automatic t_faults();
    clearMem();
    mem[0] = ins(TTL, 8'd0, 16'h7777);
    mem[1] = ins(CALL, 0, 16'd1);
    runProg(-1);
    chk("R11 call overflow cycles", nBusy, 6);
    chk("R11 call overflow flags", {busy, done, errFlag}, 3'b001);
    repeat (3) @(negedge clk);
    chk("R11 outputs held after fault", ttlOut[15:0], 16'h7777);
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    chk("R2 start ignored while errFlag", {busy, errFlag}, 2'b01);
    resetDut();
    clearMem();
    for (int i = 0; i < 5; i++) mem[i] = ins(LOOP, 0, 16'd2);
    runProg(-1);
    chk("R11 loop overflow cycles", nBusy, 5);
    chk("R11 loop overflow flag", errFlag, 1);
    resetDut();
    clearMem();
    mem[0] = ins(RET, 0, 0);
    runProg(-1);
    chk("R11 return underflow", {nBusy[3:0], errFlag, done}, {4'd1, 1'b1, 1'b0});
    resetDut();
    mem[0] = ins(ENDL, 0, 16'd0);
    runProg(-1);
    chk("R11 loop close underflow", errFlag, 1);
    resetDut();
  endtask

  task automatic t_restart();
    clearMem();
    mem[0] = insWait(36'd10);
    mem[1] = ins(TTL, 8'd0, 16'h0001);
    mem[2] = ins(HALT, 0, 0);
    runProg(5);
    chk("R2 start during run ignored", nBusy, 12);
  endtask

  task automatic t_misc();
    clearMem();
    mem[0] = {4'd12, 36'h0_0000_FFFF};
    mem[1] = ins(TTL, 8'd5, 16'hFFFF);
    mem[2] = ins(HALT, 0, 0);
    runProg(-1);
    chk("R13 undefined opcode one cycle", nBusy, 3);
    chk("R5 out-of-range word ignored", ttlOut, 32'h0);
    chk("R13 no bus activity", pulseCnt, 0);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishRun();
  end

  initial begin
    t_reset();
    t_misc();
    t_ttl_wait();
    t_wait_short();
    t_bus();
    t_jump();
    t_cond();
    t_loop();
    t_call();
    t_restart();
    t_faults();
    finishRun();
  end
endmodule